// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-up to a usable state. After reset it holds the clock enable low and deselects the device while a stabilization counter runs. It then walks a fixed list of commands: a NOP, a precharge of all banks, an extended mode register load that enables the DLL, and a mode register load that resets the DLL. A long NOP wait gives the DLL time to lock. A second precharge-all, two auto-refreshes and a final mode register load that sets CAS latency and burst length complete the list.

Each command is driven for one cycle on registered command, address and bank outputs. The spacing to the next command is a per-step count taken from the timing parameters. Once the last load has had its set time, a done flag rises and stays high until reset. The controller that follows only watches the flag. After it, the sequencer drives NOP forever.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for the first STABLE_CYC-1 cycles after it falls, `cke_o` is 0, `cmd_o` is deselect (4'b1111) and `init_done_o` is 0.
- R2: In cycle STABLE_CYC after reset falls, counting the first rising edge with reset low as cycle 1, `cke_o` goes to 1 and `cmd_o` is NOP (4'b0111). `cke_o` then stays 1.
- R3: The first non-NOP command comes NOP_GAP cycles after the NOP. It is precharge (4'b0010) with `addr_o` bit 10 set and all other address bits 0, which selects all banks.
- R4: T_RP cycles after the first precharge comes a mode load (4'b0000) to the extended register. This load has `ba_o`=01 and `addr_o`=0, so bit 0 is 0 and the DLL is enabled.
- R5: T_MRD cycles after that comes a mode load with `ba_o`=00. Its `addr_o` carries BL_CODE in [2:0], 0 in bit 3, CAS_CODE in [6:4] and 1 in bit 8 (DLL reset), with all other bits 0.
- R6: Exactly DLL_WAIT NOP cycles separate the DLL-reset load from the next command, which is a second precharge-all.
- R7: T_RP cycles after the second precharge comes auto-refresh (4'b0001), and T_RFC cycles later a second one. No other commands are issued between them and the final load.
- R8: T_RFC cycles after the second refresh comes the final mode load. It has `ba_o`=00 and the same field layout as R5, but bit 8 is 0.
- R9: Every cycle between two listed commands carries NOP, so each command appears exactly once per run.
- R10: `init_done_o` rises exactly T_MRD cycles after the final mode load. It then stays 1, with `cmd_o` at NOP, until reset.
- R11: A reset at any point of the sequence returns all outputs to the R1 state. Releasing it restarts the full sequence from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_o | output | 1 | Clock enable toward the memory |
| cmd_o | output | 4 | Command as {cs_n, ras_n, cas_n, we_n} |
| addr_o | output | ADDR_W | Address bus (mode fields, bit 10 precharge-all) |
| ba_o | output | 2 | Bank address (01 selects the extended mode register) |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The sequence is driven from a clean power-up reset with no other stimulus. This run shows whether the command order, the per-step spacing, the address and bank fields and the done timing match the schedule computed from the parameters. A second run asserts reset after the extended mode load, in the middle of the sequence. It shows whether the block restarts from stabilization rather than resuming from its old step, and whether stale commands leak out. Each run lasts well past done, so any extra command after done is caught, including a third refresh.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  // Command encoding {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_AREF  = 4'b0001;
  localparam logic [3:0] CMD_LMR   = 4'b0000;

  localparam int PRE_ALL_BIT = 10;
  localparam int DLL_RST_BIT = 8;

  typedef enum logic [2:0] {
    ST_NOP, ST_PRE1, ST_EMR, ST_MR_DLL, ST_PRE2, ST_REF1, ST_REF2, ST_MR_FINAL
  } step_t;

  typedef enum logic [1:0] {PH_STAB, PH_RUN, PH_DONE} phase_t;
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         GAP_W    = 16,
  parameter int         NOP_GAP  = 1,
  parameter int         T_RP     = 3,
  parameter int         T_RFC    = 10,
  parameter int         T_MRD    = 2,
  parameter int         DLL_WAIT = 200,
  parameter logic [2:0] CAS_CODE = 3'b010,
  parameter logic [2:0] BL_CODE  = 3'b001
) (
  input  step_t              step,
  output logic [3:0]         cmd,
  output logic [ADDR_W-1:0]  addr,
  output logic [1:0]         ba,
  output logic [GAP_W-1:0]   gap
);
  logic [ADDR_W-1:0] mode_fields;
  logic [ADDR_W-1:0] pre_all;

  always_comb begin
    mode_fields      = '0;
    mode_fields[2:0] = BL_CODE;
    mode_fields[6:4] = CAS_CODE;
    pre_all          = '0;
    pre_all[PRE_ALL_BIT] = 1'b1;
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = 2'b00;
    gap  = GAP_W'(NOP_GAP);
    unique case (step)
      ST_NOP: begin
        cmd = CMD_NOP;
        gap = GAP_W'(NOP_GAP);
      end
      ST_PRE1, ST_PRE2: begin
        cmd  = CMD_PRE;
        addr = pre_all;
        gap  = GAP_W'(T_RP);
      end
      ST_EMR: begin
        cmd = CMD_LMR;
        ba  = 2'b01;
        gap = GAP_W'(T_MRD);
      end
      ST_MR_DLL: begin
        cmd  = CMD_LMR;
        addr = mode_fields;
        addr[DLL_RST_BIT] = 1'b1;
        gap  = GAP_W'(DLL_WAIT + 1);
      end
      ST_REF1, ST_REF2: begin
        cmd = CMD_AREF;
        gap = GAP_W'(T_RFC);
      end
      ST_MR_FINAL: begin
        cmd  = CMD_LMR;
        addr = mode_fields;
        gap  = GAP_W'(T_MRD);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W     = 12,
  parameter int         STABLE_CYC = 20000,
  parameter int         NOP_GAP    = 1,
  parameter int         T_RP       = 3,
  parameter int         T_RFC      = 10,
  parameter int         T_MRD      = 2,
  parameter int         DLL_WAIT   = 200,
  parameter logic [2:0] CAS_CODE   = 3'b010,
  parameter logic [2:0] BL_CODE    = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ba_o,
  output logic              init_done_o
);
  localparam int MAX_WAIT = (STABLE_CYC > DLL_WAIT + 1) ? STABLE_CYC : DLL_WAIT + 1;
  localparam int GAP_W    = $clog2(MAX_WAIT + 1) + 1;

  phase_t             phase;
  step_t              step;
  step_t              rom_step;
  logic [3:0]         rom_cmd;
  logic [ADDR_W-1:0]  rom_addr;
  logic [1:0]         rom_ba;
  logic [GAP_W-1:0]   rom_gap;
  logic               expired;
  logic               advance;

  // Step looked up for the command that is issued next
  assign rom_step = (phase == PH_RUN) ? step_t'(step + 3'd1) : ST_NOP;
  assign advance  = expired &&
                    ((phase == PH_STAB) || (phase == PH_RUN && step != ST_MR_FINAL));

  ddr_init_step_rom #(
    .ADDR_W(ADDR_W), .GAP_W(GAP_W), .NOP_GAP(NOP_GAP), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_WAIT(DLL_WAIT),
    .CAS_CODE(CAS_CODE), .BL_CODE(BL_CODE)
  ) u_rom (
    .step(rom_step), .cmd(rom_cmd), .addr(rom_addr), .ba(rom_ba), .gap(rom_gap)
  );

  ddr_init_timer #(.W(GAP_W), .RST_VAL(STABLE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(advance), .load_val(rom_gap - 1'b1), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_STAB;
      step        <= ST_NOP;
      cke_o       <= 1'b0;
      cmd_o       <= CMD_DESEL;
      addr_o      <= '0;
      ba_o        <= 2'b00;
      init_done_o <= 1'b0;
    end else begin
      unique case (phase)
        PH_STAB: begin
          if (expired) begin
            phase  <= PH_RUN;
            step   <= ST_NOP;
            cke_o  <= 1'b1;
            cmd_o  <= rom_cmd;
            addr_o <= rom_addr;
            ba_o   <= rom_ba;
          end
        end
        PH_RUN: begin
          if (expired && step == ST_MR_FINAL) begin
            phase       <= PH_DONE;
            init_done_o <= 1'b1;
            cmd_o       <= CMD_NOP;
            addr_o      <= '0;
            ba_o        <= 2'b00;
          end else if (expired) begin
            step   <= rom_step;
            cmd_o  <= rom_cmd;
            addr_o <= rom_addr;
            ba_o   <= rom_ba;
          end else begin
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
            ba_o   <= 2'b00;
          end
        end
        default: begin
          cmd_o  <= CMD_NOP;
          addr_o <= '0;
          ba_o   <= 2'b00;
        end
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DLL_WAIT = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        ba,
  input logic              done
);
  localparam int CW = $clog2(DLL_WAIT + 1) + 1;
  logic [CW-1:0] dll_cnt;

  always_ff @(posedge clk) begin
    if (rst) dll_cnt <= '0;
    else if (cmd == CMD_LMR && ba == 2'b00 && addr[DLL_RST_BIT]) dll_cnt <= CW'(DLL_WAIT);
    else if (dll_cnt != '0) dll_cnt <= dll_cnt - 1'b1;
  end

  assert_deselect_until_cke_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cmd == CMD_DESEL);
  assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  assert_precharge_all_R3: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_PRE |-> addr[PRE_ALL_BIT]);
  assert_emr_dll_on_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR && ba == 2'b01) |-> addr == '0);
  assert_dll_settle_R6: assert property (@(posedge clk) disable iff (rst)
    dll_cnt != '0 |-> cmd == CMD_NOP);
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd == CMD_NOP);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .DLL_WAIT(DLL_WAIT)) u_chk (
  .clk(clk), .rst(rst), .cke(cke_o), .cmd(cmd_o), .addr(addr_o), .ba(ba_o),
  .done(init_done_o)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
  localparam int         ADDR_W   = 12;
  localparam int         STABLE   = 16;
  localparam int         NOP_GAP  = 2;
  localparam int         T_RP     = 3;
  localparam int         T_RFC    = 7;
  localparam int         T_MRD    = 2;
  localparam int         DLL_WAIT = 200;
  localparam logic [2:0] CAS      = 3'b010;
  localparam logic [2:0] BL       = 3'b001;

  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_AREF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_o, init_done_o;
  logic [3:0] cmd_o;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0] ba_o;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .STABLE_CYC(STABLE), .NOP_GAP(NOP_GAP), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_WAIT(DLL_WAIT), .CAS_CODE(CAS), .BL_CODE(BL)
  ) i_ddr_init_seq (
    .clk(clk), .rst(rst), .cke_o(cke_o), .cmd_o(cmd_o), .addr_o(addr_o),
    .ba_o(ba_o), .init_done_o(init_done_o)
  );

  typedef struct {
    int          cyc;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int checks = 0, errors = 0, cyc = 0, done_cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int c, logic [3:0] cm, logic [1:0] b, logic [11:0] a, string tag);
    exp_t e;
    e.cyc = c; e.cmd = cm; e.ba = b; e.addr = a; e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: schedule derived from the requirements
  task automatic push_schedule();
    int t;
    logic [11:0] mode;
    mode = {5'b0, CAS, 1'b0, BL};
    t = STABLE + NOP_GAP;
    push(t, C_PRE, 2'b00, 12'h400, "R3");
    t += T_RP;
    push(t, C_LMR, 2'b01, 12'h000, "R4");
    t += T_MRD;
    push(t, C_LMR, 2'b00, mode | 12'h100, "R5");
    t += DLL_WAIT + 1;
    push(t, C_PRE, 2'b00, 12'h400, "R6");
    t += T_RP;
    push(t, C_AREF, 2'b00, 12'h000, "R7");
    t += T_RFC;
    push(t, C_AREF, 2'b00, 12'h000, "R7");
    t += T_RFC;
    push(t, C_LMR, 2'b00, mode, "R8");
    done_cyc = t + T_MRD;
  endtask

  // Monitor: every non-NOP command is popped and compared (R9)
  always @(negedge clk) begin
    if (!rst && cmd_o != C_NOP && cmd_o != C_DESEL) begin
      if (sb.size() == 0) begin
        check(0, "R9", "unexpected command", int'(cmd_o), int'(C_NOP));
      end else begin
        cur = sb.pop_front();
        check(cyc == cur.cyc, cur.tag, "issue cycle", cyc, cur.cyc);
        check(cmd_o == cur.cmd, cur.tag, "command", int'(cmd_o), int'(cur.cmd));
        check(ba_o == cur.ba, cur.tag, "bank", int'(ba_o), int'(cur.ba));
        check(addr_o == cur.addr, cur.tag, "address", int'(addr_o), int'(cur.addr));
      end
    end
  end

  task automatic check_reset_state(string tag);
    check(cmd_o == C_DESEL, tag, "cmd in reset", int'(cmd_o), int'(C_DESEL));
    check(cke_o == 1'b0, tag, "cke in reset", int'(cke_o), 0);
    check(init_done_o == 1'b0, tag, "done in reset", int'(init_done_o), 0);
  endtask

  task automatic run_to_done(string tag);
    bit bad;
    bad = 0;
    for (int k = 1; k < STABLE; k++) begin
      @(negedge clk);
      if (cke_o !== 1'b0 || cmd_o !== C_DESEL || init_done_o !== 1'b0) bad = 1;
    end
    check(!bad, "R1", "deselect during stabilization", int'(bad), 0);
    @(negedge clk);
    check(cmd_o == C_NOP, "R2", "first command NOP", int'(cmd_o), int'(C_NOP));
    check(cke_o == 1'b1, "R2", "cke raised", int'(cke_o), 1);
    while (cyc < done_cyc - 1) @(negedge clk);
    check(init_done_o == 1'b0, "R10", "done one cycle early", int'(init_done_o), 0);
    @(negedge clk);
    check(init_done_o == 1'b1, tag, "done after final load", int'(init_done_o), 1);
  endtask

  initial begin
    bool_stay: begin end
    // Run 1: power-up
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    push_schedule();
    rst = 1'b0;
    run_to_done("R10");
    begin
      bit bad;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (init_done_o !== 1'b1 || cmd_o !== C_NOP || cke_o !== 1'b1) bad = 1;
      end
      check(!bad, "R10", "done sticky and quiet", int'(bad), 0);
    end
    check(sb.size() == 0, "R7", "commands still pending", sb.size(), 0);

    // Run 2: reset in the middle of the sequence
    rst = 1'b1;
    repeat (2) @(negedge clk);
    sb.delete();
    push_schedule();
    rst = 1'b0;
    while (cyc < STABLE + NOP_GAP + T_RP + 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("R11");
    sb.delete();
    push_schedule();
    rst = 1'b0;
    run_to_done("R11");
    repeat (10) @(negedge clk);
    check(init_done_o == 1'b1, "R11", "done held after restart", int'(init_done_o), 1);
    check(sb.size() == 0, "R11", "commands still pending", sb.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule